// File: doc/BRIEF.md
# Dword Streaming Staging Mailbox

This block is the device side of a mailbox with four 32-bit registers. The host writes a request into a single write-data port, one dword at a time. The request is framed as a 64-bit mailbox header, then a 64-bit command, then the payload dwords. A go bit in the control register makes the block judge the request in one cycle. Ready, or ready with error, then appears in the status register. A four-dword response is held for the host to drain through the read-data port. The host acknowledges each read by writing zero to that same port.

Inside, a small consumer model adds up the payload bytes of every accepted request. It reports the next image offset the host should send. When the running total reaches the image size, it reports an all-ones end marker instead. An abort bit in the control register clears the whole exchange in one cycle, including the running offset.

Top module: `mbox_stage_top`

## Requirements
- R1: After reset the status register, the control register and the read-data register all read 0.
- R2: Registers are selected by byte address: control 0x0, status 0x4, write data 0x8, read data 0xC. Control and write data read back as 0. Any access whose address bits 1:0 are nonzero has no effect.
- R3: Each write to 0x8 appends one dword to the request. Dword 0 is the header low word, which must equal {16'h000B, VENDOR_ID}. Dword 1 is the header high word: the total request length in dwords, both headers included. Dwords 2 and 3 are the command, low word first, which must equal 3. Payload dwords follow.
- R4: Writing control bit 31 with bit 0 clear is go. From the next cycle, status bit 31 (ready) reads 1. Status bit 2 (error) reads 1 in three cases: fewer than 4 dwords were received, the length word differs from the received count, or the header low word or the command is wrong.
- R5: After go, reads of 0xC return four words in order: {16'h000B, VENDOR_ID}, then 4, then the next offset, then the response status. A new go discards any undrained response and restarts at the first word.
- R6: Writing 0 to 0xC advances to the next response word. Once four words have been acknowledged, 0xC reads 0. Writing a nonzero value to 0xC leaves the current word unchanged.
- R7: An accepted request adds 4 bytes per payload dword to the running offset. While the total is below IMG_BYTES, the next offset is that total and the response status is 0x3. Once the total reaches IMG_BYTES, the next offset is 0xFFFFFFFF and the response status is 0x1.
- R8: A rejected request returns response status 0x4 and the offset reached so far, and leaves the running offset unchanged.
- R9: Writing control bit 0 is abort, and abort takes priority over go. In one cycle it clears ready, error, the write pointer, the response pointer and the running offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |

## Verification
The assertions assume that the host issues at most one register write per cycle, so go, abort, data pushes and acknowledges never coincide. They also assume a request never exceeds the write counter's range. The bench drives one write per clock through a single task and keeps every request short. It reads only between writes, half a cycle after the edge, so a read never overlaps a write.

// File: rtl/mbox_stage_pkg.sv
package mbox_stage_pkg;
  localparam logic [15:0] OBJ_STAGE = 16'h000B;
  localparam logic [63:0] CMD_LOAD  = 64'h3;
  localparam logic [31:0] END_OFF   = 32'hFFFF_FFFF;
  localparam int RSP_WORDS = 4;
  localparam int HDR_WORDS = 4;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STS  = 2'd1;
  localparam logic [1:0] SEL_WDAT = 2'd2;
  localparam logic [1:0] SEL_RDAT = 2'd3;

  localparam int CTRL_ABORT = 0;
  localparam int CTRL_GO    = 31;
  localparam int STS_READY  = 31;
  localparam int STS_ERR    = 2;

  localparam logic [31:0] RSP_ST_OK   = 32'h1;
  localparam logic [31:0] RSP_ST_BUSY = 32'h3;
  localparam logic [31:0] RSP_ST_ERR  = 32'h4;

  typedef struct packed {
    logic [31:0] cmd_hi;
    logic [31:0] cmd_lo;
    logic [31:0] hdr_hi;
    logic [31:0] hdr_lo;
  } req_hdr_t;
endpackage

// File: rtl/mbox_req_buf.sv
module mbox_req_buf
  import mbox_stage_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [31:0]      data_i,
  output req_hdr_t         hdr_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      slot_q [HDR_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (push_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
  end

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      slot_q[g] <= '0;
      else if (push_i && !clr_i && cnt_q == CNT_W'(g))  slot_q[g] <= data_i;
    end
  end

  assign hdr_o = '{cmd_hi: slot_q[3], cmd_lo: slot_q[2], hdr_hi: slot_q[1], hdr_lo: slot_q[0]};
  assign cnt_o = cnt_q;

  // R3: every accepted dword moves the write pointer by one
  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clr_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/mbox_consumer.sv
module mbox_consumer
  import mbox_stage_pkg::*;
#(
  parameter int IMG_BYTES = 48,
  parameter int CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             take_i,
  input  logic [CNT_W-1:0] data_dw_i,
  output logic [31:0]      cur_off_o,
  output logic [31:0]      next_off_o
);
  localparam int SUM_W = 34;
  localparam logic [SUM_W-1:0] IMG_LIM = SUM_W'(IMG_BYTES);

  logic [31:0]      off_q;
  logic [SUM_W-1:0] sum;
  logic             full;

  assign sum  = SUM_W'(off_q) + SUM_W'({data_dw_i, 2'b00});
  assign full = sum >= IMG_LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= '0;
    else if (clr_i)  off_q <= '0;
    else if (take_i) off_q <= full ? 32'(IMG_BYTES) : sum[31:0];
  end

  assign cur_off_o  = off_q;
  assign next_off_o = full ? END_OFF : sum[31:0];

  // R7: the running offset never passes the image size
  a_r7_off_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q <= 32'(IMG_BYTES));
endmodule

// File: rtl/mbox_rsp.sv
module mbox_rsp
  import mbox_stage_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      load_i,
  input  logic                      ack_i,
  input  logic [RSP_WORDS-1:0][31:0] words_i,
  output logic [31:0]               data_o,
  output logic [2:0]                ptr_o
);
  localparam logic [2:0] PTR_END = 3'(RSP_WORDS);

  logic [RSP_WORDS-1:0][31:0] words_q;
  logic [2:0]                 ptr_q;
  logic                       vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      words_q <= '0;
      ptr_q   <= '0;
      vld_q   <= 1'b0;
    end else if (clr_i) begin
      ptr_q   <= '0;
      vld_q   <= 1'b0;
    end else if (load_i) begin
      words_q <= words_i;
      ptr_q   <= '0;
      vld_q   <= 1'b1;
    end else if (ack_i && vld_q && ptr_q != PTR_END) begin
      ptr_q   <= ptr_q + 1'b1;
    end
  end

  assign data_o = (vld_q && ptr_q != PTR_END) ? words_q[ptr_q[1:0]] : '0;
  assign ptr_o  = ptr_q;

  // R6: the read pointer stops after the last response word
  a_r6_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PTR_END);
  // R6: an acknowledge advances exactly one word
  a_r6_ack_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !clr_i && !load_i && vld_q && ptr_q != PTR_END) |=> ptr_q == $past(ptr_q) + 1'b1);
endmodule

// File: rtl/mbox_stage_top.sv
module mbox_stage_top
  import mbox_stage_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'hA5C3,
  parameter int          IMG_BYTES = 48,
  parameter int          CNT_W     = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [3:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o
);
  localparam logic [31:0] HDR_LO_EXP = {OBJ_STAGE, VENDOR_ID};
  localparam logic [31:0] RSP_LEN    = 32'(RSP_WORDS);

  logic [1:0] sel;
  logic       aligned, ctrl_wr, abort, go, push, ack, nz_ack;
  assign sel     = addr_i[3:2];
  assign aligned = addr_i[1:0] == 2'b00;
  assign ctrl_wr = wr_en_i && aligned && sel == SEL_CTRL;
  assign abort   = ctrl_wr && wdata_i[CTRL_ABORT];
  assign go      = ctrl_wr && wdata_i[CTRL_GO] && !wdata_i[CTRL_ABORT];
  assign push    = wr_en_i && aligned && sel == SEL_WDAT;
  assign ack     = wr_en_i && aligned && sel == SEL_RDAT && wdata_i == '0;
  assign nz_ack  = wr_en_i && aligned && sel == SEL_RDAT && wdata_i != '0;

  req_hdr_t         hdr;
  logic [CNT_W-1:0] cnt;
  mbox_req_buf #(.CNT_W(CNT_W)) u_req (
    .clk_i, .rst_ni, .clr_i(abort || go), .push_i(push), .data_i(wdata_i),
    .hdr_o(hdr), .cnt_o(cnt)
  );

  logic bad;
  assign bad = cnt < CNT_W'(HDR_WORDS) || hdr.hdr_hi != 32'(cnt) ||
               hdr.hdr_lo != HDR_LO_EXP || {hdr.cmd_hi, hdr.cmd_lo} != CMD_LOAD;

  logic [31:0] cur_off, next_off;
  mbox_consumer #(.IMG_BYTES(IMG_BYTES), .CNT_W(CNT_W)) u_cons (
    .clk_i, .rst_ni, .clr_i(abort), .take_i(go && !bad),
    .data_dw_i(cnt - CNT_W'(HDR_WORDS)), .cur_off_o(cur_off), .next_off_o(next_off)
  );

  logic [RSP_WORDS-1:0][31:0] rsp_words;
  always_comb begin
    rsp_words[0] = HDR_LO_EXP;
    rsp_words[1] = RSP_LEN;
    rsp_words[2] = bad ? cur_off : next_off;
    rsp_words[3] = bad ? RSP_ST_ERR : (next_off == END_OFF ? RSP_ST_OK : RSP_ST_BUSY);
  end

  logic [31:0] rsp_data;
  logic [2:0]  rsp_ptr;
  mbox_rsp u_rsp (
    .clk_i, .rst_ni, .clr_i(abort), .load_i(go), .ack_i(ack),
    .words_i(rsp_words), .data_o(rsp_data), .ptr_o(rsp_ptr)
  );

  logic ready_q, err_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (abort) begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (go) begin
      ready_q <= 1'b1;
      err_q   <= bad;
    end
  end

  logic [31:0] sts;
  always_comb begin
    sts = '0;
    sts[STS_READY] = ready_q;
    sts[STS_ERR]   = err_q;
  end

  always_comb begin
    unique case (sel)
      SEL_STS:  rdata_o = sts;
      SEL_RDAT: rdata_o = rsp_data;
      default:  rdata_o = '0;
    endcase
  end

  // R4: go always produces ready on the following cycle
  a_r4_go_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go |=> ready_q);
  // R4: error is only ever reported together with ready
  a_r4_err_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> ready_q);
  // R9: abort clears all exchange state in one cycle
  a_r9_abort_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort |=> (!ready_q && !err_q && cnt == '0 && rsp_ptr == '0 && cur_off == '0));
  // R6: a nonzero write to the read port does not move the response
  a_r6_nz_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nz_ack |=> $stable(rsp_ptr));
endmodule

// File: tb/tb_mbox_stage_top.sv
`timescale 1ns/1ps
module tb_mbox_stage_top;
  localparam logic [15:0] VID = 16'hA5C3;
  localparam logic [31:0] W0  = {16'h000B, VID};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int n_cmp = 0;
  int n_bad = 0;

  mbox_stage_top #(.VENDOR_ID(VID), .IMG_BYTES(48), .CNT_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic send(input logic [31:0] lo, input logic [31:0] len, input logic [31:0] cmd, input int n);
    wr(4'h8, lo);
    wr(4'h8, len);
    wr(4'h8, cmd);
    wr(4'h8, 32'h0);
    for (int i = 0; i < n; i++) wr(4'h8, 32'hD000_0000 + i);
    wr(4'h0, 32'h8000_0000);
  endtask

  task automatic drain(input string tag, input logic [31:0] off, input logic [31:0] st);
    logic [31:0] v;
    rd(4'hC, v); chk({tag, " R5 w0"}, v, W0);     wr(4'hC, 0);
    rd(4'hC, v); chk({tag, " R5 w1"}, v, 32'd4);  wr(4'hC, 0);
    rd(4'hC, v); chk({tag, " R7 offset"}, v, off); wr(4'hC, 0);
    rd(4'hC, v); chk({tag, " R7 status"}, v, st); wr(4'hC, 0);
    rd(4'hC, v); chk({tag, " R6 drained"}, v, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'h4, v); chk("R1 status", v, 32'h0);
    rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
    rd(4'hC, v); chk("R1 rdata", v, 32'h0);
  endtask

  task automatic t_first;
    logic [31:0] v;
    send(W0, 32'd8, 32'd3, 4);
    rd(4'h4, v); chk("R4 ready", v, 32'h8000_0000);
    rd(4'h8, v); chk("R2 wdata reads 0", v, 32'h0);
    wr(4'hC, 32'h5);
    rd(4'hC, v); chk("R6 nonzero ack ignored", v, W0);
    drain("first", 32'd16, 32'h3);
  endtask

  task automatic t_final;
    logic [31:0] v;
    send(W0, 32'd12, 32'd3, 8);
    rd(4'h4, v); chk("R4 final ready", v, 32'h8000_0000);
    drain("final R7", 32'hFFFF_FFFF, 32'h1);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    wr(4'h0, 32'h1);
    rd(4'h4, v); chk("R9 status cleared", v, 32'h0);
    rd(4'hC, v); chk("R9 response cleared", v, 32'h0);
    send(W0, 32'd8, 32'd3, 4);
    drain("R9 offset restart", 32'd16, 32'h3);
  endtask

  task automatic t_len_bad;
    logic [31:0] v;
    send(W0, 32'd9, 32'd3, 4);
    rd(4'h4, v); chk("R4 length error", v, 32'h8000_0004);
    drain("R8 len", 32'd16, 32'h4);
    send(W0, 32'd8, 32'd3, 4);
    drain("R8 unchanged", 32'd32, 32'h3);
  endtask

  task automatic t_other_bad;
    logic [31:0] v;
    send(W0, 32'd8, 32'd5, 4);
    rd(4'h4, v); chk("R4 bad cmd", v, 32'h8000_0004);
    drain("R8 cmd", 32'd32, 32'h4);
    send(32'h000B_1111, 32'd8, 32'd3, 4);
    rd(4'h4, v); chk("R3 bad header", v, 32'h8000_0004);
    wr(4'h8, W0);
    wr(4'h8, 32'd2);
    wr(4'h0, 32'h8000_0000);
    rd(4'h4, v); chk("R4 short request", v, 32'h8000_0004);
    drain("R8 short", 32'd32, 32'h4);
  endtask

  task automatic t_replace;
    logic [31:0] v;
    send(W0, 32'd5, 32'd3, 1);
    wr(4'hC, 0);
    wr(4'hC, 0);
    send(W0, 32'd5, 32'd3, 1);
    drain("R5 replace", 32'd40, 32'h3);
  endtask

  task automatic t_go_abort;
    logic [31:0] v;
    wr(4'h0, 32'h8000_0001);
    rd(4'h4, v); chk("R9 abort beats go", v, 32'h0);
    wr(4'h1, 32'h8000_0000);
    rd(4'h4, v); chk("R2 misaligned ignored", v, 32'h0);
    send(W0, 32'd8, 32'd3, 4);
    drain("R9 after abort+go", 32'd16, 32'h3);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first();
    t_final();
    t_abort();
    t_len_bad();
    t_other_bad();
    t_replace();
    t_go_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule